// File: doc/BRIEF.md
# Multichannel Ultrasound Transmit Pulse Generator

This block produces the digital excitation bursts for a nine-element ultrasound transducer array. A host first writes per-channel settings (an enable bit and a 5-bit start delay) and one shared control word. The control word holds the burst length, the pulse-rate code, the waveform (square or stepped sine) and the firing mode (all enabled channels, or one selected channel). A single fire strobe then launches every participating channel. Each channel starts its burst a programmed number of phase ticks after the strobe, so the array can steer or focus the beam.

Timing is counted in phase ticks. A tick lasts 2^k clock cycles, where k comes from the rate code, and one pulse cycle is 16 ticks. Each channel drives a 1-bit polarity output and an 8-bit offset-binary amplitude. In sine mode the amplitude is stepped once per tick through a 16-point table.

At the strobe, the block copies all settings into working registers. Register writes made while a burst is running therefore only apply to the next fire. A busy flag covers the whole burst of the latest-starting channel.

Top module: `ustx_pulse_gen`

## Requirements
- R1: After reset, `busy_o` is 0, every `tx_drive_o` bit is 0 and every amplitude lane reads 128. All channels are disabled with delay 0, and the control word holds burst length 1, rate code 1, square waveform, multi-channel mode and select 0.
- R2: A write with `wr_addr` below 9 sets channel `wr_addr` to {enable = `wr_data[5]`, delay = `wr_data[4:0]`}. A write to address 15 sets the control word: burst `wr_data[3:0]`, rate code `wr_data[6:4]`, waveform `wr_data[7]` (1 = sine), mode `wr_data[8]` (1 = single) and select `wr_data[12:9]`. On an accepted fire, a channel with delay d is active from tick d through tick d+16·N−1, where N is the burst length and tick 0 starts on the cycle after the strobe edge.
- R3: Rate codes 0 to 5 give a tick of 2^code clock cycles. Codes 6 and 7 behave as the default code 1 (2 cycles per tick).
- R4: While a channel is active in tick t, let p = (t−d) mod 16. Its drive bit is 1 when p < 8. Its amplitude is 255/1 for p < 8 / p ≥ 8 in square mode, and round(128 + 127·sin(2πp/16)) in sine mode.
- R5: If the burst length is 0, a fire strobe is ignored: busy stays low and no output changes.
- R6: In multi-channel mode, exactly the enabled channels fire. In single mode, only the selected channel fires, whatever its enable bit. A select of 9 or more, or a fire with no participating channel, is ignored.
- R7: A fire strobe while `busy_o` is high is ignored and does not restart or extend the burst.
- R8: After an accepted fire, `busy_o` is high for exactly (D+16·N)·2^k cycles. D is the largest delay among the participating channels.
- R9: Channel and control writes made during a burst do not alter that burst; they take effect at the next fire.
- R10: While idle, every drive bit is 0 and every amplitude lane is 128. An enabled channel outside its active window shows the same idle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register address (0..8 channels, 15 control) |
| wr_data | input | 13 | Register write data |
| fire_i | input | 1 | Fire strobe |
| busy_o | output | 1 | Burst in progress |
| tx_drive_o | output | 9 | Per-channel drive polarity |
| tx_amp_o | output | 72 | Per-channel 8-bit amplitude, channel i in bits [8i+7:8i] |

## Verification
Two events can land in the same cycle: a new fire strobe and a register write, both while a burst is running. The bench raises both together partway through a burst. The write changes the burst length and the waveform at once.

The bench checks that the running burst matches its cycle-by-cycle model of the settings copied at the original strobe. It checks that `busy_o` falls at the computed cycle and not later. It then checks that the next fire follows the new settings. Every cycle of every burst is compared against an arithmetic model for all nine lanes.

// File: rtl/ustx_pkg.sv
package ustx_pkg;

    localparam int ADDR_W    = 4;
    localparam int DLY_W     = 5;
    localparam int BURST_W   = 4;
    localparam int FC_W      = 3;
    localparam int SEL_W     = 4;
    localparam int AMP_W     = 8;
    localparam int PH_W      = 4;
    localparam int MAX_LOG   = 5;
    localparam int LOG_W     = 3;
    localparam int DEF_LOG   = 1;
    localparam int CTRL_ADDR = 15;
    localparam int CNT_W     = $clog2((1 << DLY_W) + (1 << BURST_W) * (1 << PH_W));
    localparam logic [AMP_W-1:0] AMP_MID = 8'd128;

    typedef enum logic {WAVE_SQUARE = 1'b0, WAVE_SINE = 1'b1} wave_e;
    typedef enum logic {MODE_MULTI = 1'b0, MODE_SINGLE = 1'b1} mode_e;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        mode_e              mode;
        wave_e              wave;
        logic [FC_W-1:0]    fcode;
        logic [BURST_W-1:0] burst;
    } ctrl_t;

    typedef struct packed {
        logic             en;
        logic [DLY_W-1:0] dly;
    } chcfg_t;

    localparam int WR_W = $bits(ctrl_t);

    function automatic logic [LOG_W-1:0] rate_log(input logic [FC_W-1:0] code);
        if (code <= FC_W'(MAX_LOG)) return LOG_W'(code);
        return LOG_W'(DEF_LOG);
    endfunction

    function automatic logic [AMP_W-1:0] sine_step(input logic [PH_W-1:0] ph);
        case (ph)
            4'd0:  return 8'd128;
            4'd1:  return 8'd177;
            4'd2:  return 8'd218;
            4'd3:  return 8'd245;
            4'd4:  return 8'd255;
            4'd5:  return 8'd245;
            4'd6:  return 8'd218;
            4'd7:  return 8'd177;
            4'd8:  return 8'd128;
            4'd9:  return 8'd79;
            4'd10: return 8'd38;
            4'd11: return 8'd11;
            4'd12: return 8'd1;
            4'd13: return 8'd11;
            4'd14: return 8'd38;
            default: return 8'd79;
        endcase
    endfunction

    function automatic logic [AMP_W-1:0] square_step(input logic [PH_W-1:0] ph);
        return ph[PH_W-1] ? 8'd1 : 8'd255;
    endfunction

endpackage

// File: rtl/ustx_tick_gen.sv
module ustx_tick_gen
    import ustx_pkg::*;
#(
    parameter int PRE_W = MAX_LOG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic [LOG_W-1:0] div_log,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    assign limit = PRE_W'((32'd1 << div_log) - 32'd1);
    assign tick  = run && (pre_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/ustx_seq.sv
module ustx_seq
    import ustx_pkg::*;
#(
    parameter int NUM_CH = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire_ok,
    input  logic [NUM_CH-1:0]       fire_mask,
    input  logic [NUM_CH*DLY_W-1:0] dly_flat,
    input  logic [BURST_W-1:0]      burst,
    input  logic                    tick,
    output logic                    busy,
    output logic [CNT_W-1:0]        tcnt
);
    logic [DLY_W-1:0] max_dly;
    logic [CNT_W-1:0] end_d;
    logic [CNT_W-1:0] end_q;

    always_comb begin
        max_dly = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (fire_mask[i] && (dly_flat[i*DLY_W +: DLY_W] > max_dly)) begin
                max_dly = dly_flat[i*DLY_W +: DLY_W];
            end
        end
        end_d = CNT_W'(max_dly) + (CNT_W'(burst) << PH_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            tcnt  <= '0;
            end_q <= '0;
        end else if (fire_ok) begin
            busy  <= 1'b1;
            tcnt  <= '0;
            end_q <= end_d;
        end else if (busy && tick) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt + 1'b1 == end_q) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/ustx_chan.sv
module ustx_chan
    import ustx_pkg::*;
(
    input  logic               busy,
    input  logic               en,
    input  logic [DLY_W-1:0]   dly,
    input  logic [BURST_W-1:0] burst,
    input  wave_e              wave,
    input  logic [CNT_W-1:0]   tcnt,
    output logic               active,
    output logic               drive,
    output logic [AMP_W-1:0]   amp
);
    logic [CNT_W-1:0] rel;
    logic [CNT_W-1:0] span;
    logic [PH_W-1:0]  ph;

    assign rel    = tcnt - CNT_W'(dly);
    assign span   = CNT_W'(burst) << PH_W;
    assign ph     = rel[PH_W-1:0];
    assign active = busy && en && (tcnt >= CNT_W'(dly)) && (rel < span);

    always_comb begin
        drive = 1'b0;
        amp   = AMP_MID;
        if (active) begin
            drive = !ph[PH_W-1];
            amp   = (wave == WAVE_SINE) ? sine_step(ph) : square_step(ph);
        end
    end
endmodule

// File: rtl/ustx_pulse_gen.sv
module ustx_pulse_gen
    import ustx_pkg::*;
#(
    parameter int NUM_CH = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WR_W-1:0]         wr_data,
    input  logic                    fire_i,
    output logic                    busy_o,
    output logic [NUM_CH-1:0]       tx_drive_o,
    output logic [NUM_CH*AMP_W-1:0] tx_amp_o
);
    chcfg_t ch_q [NUM_CH];
    ctrl_t  ctrl_q;

    logic [NUM_CH-1:0]       fire_mask;
    logic                    fire_ok;
    logic [NUM_CH*DLY_W-1:0] live_dly;

    logic [NUM_CH-1:0]       cap_mask;
    logic [NUM_CH*DLY_W-1:0] cap_dly;
    logic [BURST_W-1:0]      cap_burst;
    wave_e                   cap_wave;
    logic [LOG_W-1:0]        cap_log;
    logic                    cap_single;

    logic                    tick;
    logic [CNT_W-1:0]        tcnt;
    logic [NUM_CH-1:0]       chan_active;
    logic [BURST_W-1:0]      cfg_burst;

    assign cfg_burst = ctrl_q.burst;

    // host register file
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) ch_q[i] <= '0;
            ctrl_q <= '{sel: '0, mode: MODE_MULTI, wave: WAVE_SQUARE,
                        fcode: FC_W'(DEF_LOG), burst: BURST_W'(1)};
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(CTRL_ADDR)) begin
                ctrl_q <= ctrl_t'(wr_data);
            end else if (wr_addr < ADDR_W'(NUM_CH)) begin
                ch_q[wr_addr] <= chcfg_t'(wr_data[$bits(chcfg_t)-1:0]);
            end
        end
    end

    // participating channels, from the live settings
    always_comb begin
        fire_mask = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ctrl_q.mode == MODE_SINGLE) fire_mask[i] = (ctrl_q.sel == SEL_W'(i));
            else                            fire_mask[i] = ch_q[i].en;
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_live
            assign live_dly[g*DLY_W +: DLY_W] = ch_q[g].dly;
        end
    endgenerate

    assign fire_ok = fire_i && !busy_o && (ctrl_q.burst != '0) && (fire_mask != '0);

    // working copy taken at the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_mask   <= '0;
            cap_dly    <= '0;
            cap_burst  <= '0;
            cap_wave   <= WAVE_SQUARE;
            cap_log    <= LOG_W'(DEF_LOG);
            cap_single <= 1'b0;
        end else if (fire_ok) begin
            cap_mask   <= fire_mask;
            cap_dly    <= live_dly;
            cap_burst  <= ctrl_q.burst;
            cap_wave   <= ctrl_q.wave;
            cap_log    <= rate_log(ctrl_q.fcode);
            cap_single <= (ctrl_q.mode == MODE_SINGLE);
        end
    end

    ustx_tick_gen u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (busy_o),
        .clear   (fire_ok),
        .div_log (cap_log),
        .tick    (tick)
    );

    ustx_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fire_ok   (fire_ok),
        .fire_mask (fire_mask),
        .dly_flat  (live_dly),
        .burst     (ctrl_q.burst),
        .tick      (tick),
        .busy      (busy_o),
        .tcnt      (tcnt)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
            ustx_chan u_chan (
                .busy   (busy_o),
                .en     (cap_mask[g]),
                .dly    (cap_dly[g*DLY_W +: DLY_W]),
                .burst  (cap_burst),
                .wave   (cap_wave),
                .tcnt   (tcnt),
                .active (chan_active[g]),
                .drive  (tx_drive_o[g]),
                .amp    (tx_amp_o[g*AMP_W +: AMP_W])
            );
        end
    endgenerate
endmodule

// File: rtl/ustx_pulse_gen_chk.sv
module ustx_pulse_gen_chk
    import ustx_pkg::*;
#(
    parameter int NUM_CH = 9
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    fire_i,
    input logic                    fire_ok,
    input logic                    busy_o,
    input logic                    tick,
    input logic                    cap_single,
    input logic [CNT_W-1:0]        tcnt,
    input logic [BURST_W-1:0]      cfg_burst,
    input logic [NUM_CH-1:0]       chan_active,
    input logic [NUM_CH-1:0]       tx_drive_o,
    input logic [NUM_CH*AMP_W-1:0] tx_amp_o
);
    logic all_mid;
    always_comb begin
        all_mid = 1'b1;
        for (int i = 0; i < NUM_CH; i++) begin
            if (tx_amp_o[i*AMP_W +: AMP_W] != AMP_MID) all_mid = 1'b0;
        end
    end

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (tx_drive_o == '0) && all_mid);

    a_r2_fire_starts: assert property (@(posedge clk) disable iff (rst)
        fire_ok |=> busy_o);

    a_r5_zero_burst_ignored: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && fire_i && cfg_burst == '0) |=> !busy_o);

    a_r6_single_onehot: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cap_single) |-> $onehot0(chan_active));

    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy_o && fire_i && tcnt != '0) |=> (tcnt != '0 || !busy_o));

    a_r8_busy_ends_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(tick));
endmodule

bind ustx_pulse_gen ustx_pulse_gen_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fire_i      (fire_i),
    .fire_ok     (fire_ok),
    .busy_o      (busy_o),
    .tick        (tick),
    .cap_single  (cap_single),
    .tcnt        (tcnt),
    .cfg_burst   (cfg_burst),
    .chan_active (chan_active),
    .tx_drive_o  (tx_drive_o),
    .tx_amp_o    (tx_amp_o)
);

// File: tb/ustx_pulse_gen_bench.sv
module ustx_pulse_gen_bench;
    localparam int NCH = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [12:0] wr_data = '0;
    logic        fire_i = 1'b0;
    logic        busy_o;
    logic [NCH-1:0]   tx_drive_o;
    logic [NCH*8-1:0] tx_amp_o;

    ustx_pulse_gen u_ustx_pulse_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fire_i(fire_i), .busy_o(busy_o), .tx_drive_o(tx_drive_o), .tx_amp_o(tx_amp_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // shadow of host settings
    bit      b_en  [NCH];
    int      b_dly [NCH];
    int      b_burst = 1, b_fc = 1, b_sel = 0;
    bit      b_sine = 0, b_single = 0;

    // snapshot for the running burst
    bit      s_part [NCH];
    int      s_dly  [NCH];
    int      s_burst, s_log;
    bit      s_sine;

    function automatic int sine_ref(int p);
        real v = 128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * p / 16.0);
        return int'(v);
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en = 1; wr_addr = 4'(addr); wr_data = 13'(data);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic set_ch(int ch, bit en, int dly);
        b_en[ch] = en; b_dly[ch] = dly;
        wr(ch, (int'(en) << 5) | dly);
    endtask

    function automatic int ctrl_word(int burst, int fc, bit sine, bit single, int sel);
        return burst | (fc << 4) | (int'(sine) << 7) | (int'(single) << 8) | (sel << 9);
    endfunction

    task automatic shadow_ctrl(int w);
        b_burst = w & 15; b_fc = (w >> 4) & 7; b_sine = w[7];
        b_single = w[8]; b_sel = (w >> 9) & 15;
    endtask

    task automatic set_ctrl(int burst, int fc, bit sine, bit single, int sel);
        int w = ctrl_word(burst, fc, sine, single, sel);
        shadow_ctrl(w);
        wr(15, w);
    endtask

    task automatic check_idle(string tag);
        bit ok = (busy_o == 0) && (tx_drive_o == '0);
        for (int i = 0; i < NCH; i++) if (tx_amp_o[i*8 +: 8] != 8'd128) ok = 0;
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s idle: busy=%0b drive=%h amp=%h expected busy=0 drive=0 amp=all 80",
                     tag, busy_o, tx_drive_o, tx_amp_o);
        end
    endtask

    // one full burst, compared cycle by cycle; optional refire + ctrl write at inj_c
    task automatic run_burst(string tag, int inj_c, int inj_ctrl);
        int any = 0, maxd = 0, total;
        for (int i = 0; i < NCH; i++) begin
            s_part[i] = b_single ? (b_sel == i) : b_en[i];
            s_dly[i]  = b_dly[i];
            if (s_part[i]) begin
                any = 1;
                if (s_dly[i] > maxd) maxd = s_dly[i];
            end
        end
        s_burst = b_burst; s_sine = b_sine;
        s_log = (b_fc <= 5) ? b_fc : 1;
        @(negedge clk); fire_i = 1;
        @(negedge clk); fire_i = 0;
        if (s_burst == 0 || !any) begin
            for (int c = 0; c < 20; c++) begin
                check_idle(tag);
                @(negedge clk);
            end
            return;
        end
        total = (maxd + 16 * s_burst) << s_log;
        for (int c = 0; c < total + 4; c++) begin
            logic [NCH-1:0]   e_drv = '0;
            logic [NCH*8-1:0] e_amp;
            bit e_busy = (c < total);
            int t = c >> s_log;
            for (int i = 0; i < NCH; i++) begin
                int p;
                e_amp[i*8 +: 8] = 8'd128;
                if (e_busy && s_part[i] && t >= s_dly[i] && (t - s_dly[i]) < 16 * s_burst) begin
                    p = (t - s_dly[i]) % 16;
                    e_drv[i] = (p < 8);
                    e_amp[i*8 +: 8] = s_sine ? 8'(sine_ref(p)) : ((p < 8) ? 8'd255 : 8'd1);
                end
            end
            checks++;
            if (busy_o !== e_busy || tx_drive_o !== e_drv || tx_amp_o !== e_amp) begin
                fails++;
                $display("FAIL %s c=%0d: busy=%0b drive=%h amp=%h expected busy=%0b drive=%h amp=%h",
                         tag, c, busy_o, tx_drive_o, tx_amp_o, e_busy, e_drv, e_amp);
            end
            if (c == inj_c) begin
                fire_i = 1; wr_en = 1; wr_addr = 4'd15; wr_data = 13'(inj_ctrl);
                shadow_ctrl(inj_ctrl);
            end
            @(negedge clk);
            fire_i = 0; wr_en = 0;
        end
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin b_en[i] = 0; b_dly[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_idle("R1 reset");

        // R6: nothing enabled -> fire ignored
        run_burst("R6 no channel", -1, 0);

        // R2: defaults (burst 1, code 1, square), one channel
        set_ch(0, 1, 0);
        run_burst("R2 defaults", -1, 0);

        // R3: every rate code, square, staggered delays
        for (int i = 0; i < NCH; i++) set_ch(i, (i % 3) != 1, (3 * i) % 32);
        for (int fc = 0; fc < 8; fc++) begin
            set_ctrl(1, fc, 0, 0, 0);
            run_burst("R3 rate", -1, 0);
        end

        // R4: sine and square, longer bursts
        for (int i = 0; i < NCH; i++) set_ch(i, 1, 2 * i);
        set_ctrl(2, 0, 1, 0, 0);  run_burst("R4 sine", -1, 0);
        set_ctrl(3, 2, 1, 0, 0);  run_burst("R4 sine slow", -1, 0);
        set_ctrl(2, 0, 0, 0, 0);  run_burst("R4 square", -1, 0);

        // R5: zero burst
        set_ctrl(0, 0, 0, 0, 0);  run_burst("R5 zero burst", -1, 0);

        // R6: single mode, selected channel disabled still fires; out-of-range select
        set_ch(4, 0, 5);
        set_ctrl(1, 0, 1, 1, 4);  run_burst("R6 single", -1, 0);
        set_ctrl(1, 0, 1, 1, 12); run_burst("R6 bad select", -1, 0);

        // R7 + R9: refire and control write in the same cycle mid-burst
        set_ctrl(3, 0, 0, 0, 0);
        run_burst("R7 R9 refire+write", 10, ctrl_word(5, 1, 1, 0, 0));
        run_burst("R9 new settings", -1, 0);

        // R8 / R10: longest delay, longest burst
        set_ch(8, 1, 31);
        set_ctrl(15, 0, 0, 0, 0); run_burst("R8 max window", -1, 0);
        check_idle("R10 after burst");

        done = 1;
        summary();
    end
endmodule